// File: doc/BRIEF.md
# USB High-Speed Microframe Interval Timer

This block paces a USB host controller's high-speed schedule. It runs from a 30 MHz reference clock and produces a single-cycle start strobe at each 125 µs microframe boundary. It also keeps a 3-bit microframe index and an 11-bit frame number. One reference cycle equals 16 high-speed bit times, because 480 MHz / 30 MHz = 16.

The length of each microframe is a fixed base count plus a 6-bit software adjustment. Each adjustment step adds one reference cycle. The reset value of 32 gives the nominal 3750-cycle (125 µs) interval. Software raises the adjustment when the reference clock runs slow and lowers it when the clock runs fast. A new adjustment is first captured into a pending register. It is moved into use only at a microframe boundary, so the microframe in progress keeps the length it started with.

Top module: `usb_ufrm_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the strobe, the microframe index, the frame number and the internal cycle count, and restores the adjustment to 32.
- R2: With `en` held high, consecutive start strobes are exactly BASE_COUNT + adj enabled clock cycles apart. With the default BASE_COUNT of 3718 and adj of 32, this is 3750 cycles.
- R3: `sof_pulse` is high for exactly one clock cycle per microframe.
- R4: A value presented on `adj_value` while `adj_load` is high is applied from the next microframe boundary onward. The microframe in progress keeps its length. The load must come at least one cycle before that boundary.
- R5: `ufrm_index` advances by one, modulo 8, in the same cycle that `sof_pulse` is high, and does not change at any other time.
- R6: `frame_num` advances by one in the strobe cycle in which `ufrm_index` wraps from 7 to 0, and wraps from 2047 to 0. It does not change at any other time.
- R7: While `en` is low, the cycle count, index and frame number hold their values and no strobe is produced. Counting resumes from where it stopped once `en` is high again.
- R8: After reset is released with `en` high, the first strobe comes BASE_COUNT + 32 enabled cycles later.
- R9: The adjustment is a 6-bit unsigned number. A value of 0 gives a period of BASE_COUNT cycles, and a value of 63 gives BASE_COUNT + 63 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 30 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable; while low, all counters hold |
| adj_load | input | 1 | Strobe that captures `adj_value` into the pending adjustment |
| adj_value | input | 6 | Frame-length adjustment, one reference cycle per step |
| sof_pulse | output | 1 | One-cycle microframe start strobe |
| ufrm_index | output | 3 | Microframe index within the frame |
| frame_num | output | 11 | Frame number |

## Verification
The strobe is registered, so it rises in the cycle after the clock edge at which the count reaches its final value. That makes P enabled edges from one strobe to the next. The index and frame number change on the same edge as the strobe, so they are checked in the strobe cycle. A load takes effect one full period later: the period in progress keeps the old length, and the following period uses the new one. The bench drives and samples on falling edges and counts falling edges between observed strobes, so every expected count is a whole number of enabled rising edges.

// File: rtl/ufrm_pkg.sv
// Package: shared defaults and helpers for the microframe interval timer.
// Assumes: the adjustment step is one reference clock cycle.
package ufrm_pkg;

    // Default number of reference cycles in a microframe when the adjustment is 0.
    localparam int unsigned UFRM_BASE_DEFAULT = 3718;
    // Adjustment value restored by reset (nominal 125 us period).
    localparam int unsigned UFRM_ADJ_NOMINAL  = 32;
    // Adjustment field width.
    localparam int unsigned UFRM_ADJ_BITS     = 6;
    // Microframe index width (8 microframes per frame).
    localparam int unsigned UFRM_IDX_BITS     = 3;
    // Frame number width.
    localparam int unsigned UFRM_FRAME_BITS   = 11;

    // Width needed to count the longest possible microframe.
    function automatic int unsigned ufrm_count_bits(input int unsigned base,
                                                    input int unsigned adj_bits);
        int unsigned longest;
        longest = base + (32'd1 << adj_bits);
        return (longest < 2) ? 1 : $clog2(longest);
    endfunction

endpackage

// File: rtl/ufrm_adj_shadow.sv
// Module: adjustment shadow register pair.
// Captures software writes into a pending register and moves that value into
// the active register only at a microframe boundary.
// Assumes: a load and a boundary in the same cycle is resolved by moving the
// old pending value; the new one is applied one boundary later.
module ufrm_adj_shadow #(
    parameter int unsigned ADJ_W     = 6,
    parameter int unsigned ADJ_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ADJ_W-1:0] value,
    input  logic             boundary,
    output logic [ADJ_W-1:0] active
);

    localparam logic [ADJ_W-1:0] RESET_VAL = ADJ_W'(ADJ_RESET);

    logic [ADJ_W-1:0] pending;

    // Pending register: holds the latest value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= RESET_VAL;
        end else if (load) begin
            pending <= value;
        end
    end

    // Active register: updated only when a microframe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= RESET_VAL;
        end else if (boundary) begin
            active <= pending;
        end
    end

endmodule

// File: rtl/ufrm_period_counter.sv
// Module: microframe period counter.
// Counts enabled reference cycles from 0 up to BASE + adj - 1 and flags the
// last cycle of each microframe.
// Assumes: BASE >= 2, so that a period is always at least two cycles long.
module ufrm_period_counter #(
    parameter int unsigned BASE  = 3718,
    parameter int unsigned ADJ_W = 6,
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ADJ_W-1:0] adj,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE - 1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last;

    // Final count value of the current microframe.
    always_comb begin
        last = BASE_M1 + CNT_W'(adj);
    end

    // The last cycle of a microframe, seen only while enabled.
    always_comb begin
        wrap = en && (count == last);
    end

    // Cycle counter: advances when enabled and restarts after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ufrm_index_counter.sv
// Module: microframe index and frame number counters.
// Advances the index on each microframe boundary and the frame number when
// the index rolls over.
// Assumes: advance is high for one cycle per boundary.
module ufrm_index_counter #(
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [IDX_W-1:0]   index,
    output logic [FRAME_W-1:0] frame
);

    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    logic roll;

    // The index is about to wrap back to zero.
    always_comb begin
        roll = advance && (index == IDX_LAST);
    end

    // Microframe index, modulo 2**IDX_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (advance) begin
            index <= index + 1'b1;
        end
    end

    // Frame number, modulo 2**FRAME_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (roll) begin
            frame <= frame + 1'b1;
        end
    end

endmodule

// File: rtl/usb_ufrm_timer.sv
// Module: USB high-speed microframe interval timer (top level).
// Generates a one-cycle start strobe every BASE_COUNT + adj reference cycles.
// Also keeps a microframe index and a frame number.
// Assumes: clk is the 30 MHz reference; software loads the adjustment at
// least one cycle before the boundary at which it should apply.
module usb_ufrm_timer
    import ufrm_pkg::*;
#(
    parameter int unsigned BASE_COUNT = UFRM_BASE_DEFAULT,
    parameter int unsigned ADJ_W      = UFRM_ADJ_BITS,
    parameter int unsigned ADJ_RESET  = UFRM_ADJ_NOMINAL,
    parameter int unsigned IDX_W      = UFRM_IDX_BITS,
    parameter int unsigned FRAME_W    = UFRM_FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               adj_load,
    input  logic [ADJ_W-1:0]   adj_value,
    output logic               sof_pulse,
    output logic [IDX_W-1:0]   ufrm_index,
    output logic [FRAME_W-1:0] frame_num
);

    localparam int unsigned CNT_W = ufrm_count_bits(BASE_COUNT, ADJ_W);

    logic             boundary;
    logic [ADJ_W-1:0] adj_active;

    ufrm_adj_shadow #(
        .ADJ_W    (ADJ_W),
        .ADJ_RESET(ADJ_RESET)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (adj_load),
        .value   (adj_value),
        .boundary(boundary),
        .active  (adj_active)
    );

    ufrm_period_counter #(
        .BASE (BASE_COUNT),
        .ADJ_W(ADJ_W),
        .CNT_W(CNT_W)
    ) u_period (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .adj  (adj_active),
        .wrap (boundary)
    );

    ufrm_index_counter #(
        .IDX_W  (IDX_W),
        .FRAME_W(FRAME_W)
    ) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(boundary),
        .index  (ufrm_index),
        .frame  (frame_num)
    );

    // Start strobe: registered copy of the boundary, so it aligns with the new index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= boundary;
        end
    end

endmodule

// File: rtl/usb_ufrm_timer_checker.sv
// Module: property checker for the microframe interval timer, bound to the top.
// Assumes: reset is held low for at least one clock edge at start-up.
module usb_ufrm_timer_checker #(
    parameter int unsigned BASE_COUNT = 3718,
    parameter int unsigned ADJ_W      = 6,
    parameter int unsigned ADJ_RESET  = 32,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned FRAME_W    = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               sof_pulse,
    input logic [IDX_W-1:0]   ufrm_index,
    input logic [FRAME_W-1:0] frame_num,
    input logic [ADJ_W-1:0]   adj_active
);

    localparam int unsigned GAP_W = $clog2(BASE_COUNT + (32'd1 << ADJ_W)) + 2;

    logic             past_ok = 1'b0;
    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] expect_gap;

    // Marks cycles whose previous sample was taken after reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // Counts enabled edges since the last strobe and latches the next expected period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap        <= '0;
            expect_gap <= GAP_W'(BASE_COUNT + ADJ_RESET);
        end else if (sof_pulse) begin
            gap        <= en ? GAP_W'(1) : '0;
            expect_gap <= GAP_W'(BASE_COUNT) + GAP_W'(adj_active);
        end else if (en) begin
            gap <= gap + 1'b1;
        end
    end

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> gap == expect_gap);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);

    assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sof_pulse) |-> ufrm_index == IDX_W'($past(ufrm_index) + 1'b1));

    assert_index_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !sof_pulse) |-> $stable(ufrm_index));

    assert_frame_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sof_pulse && ufrm_index == '0) |-> frame_num == FRAME_W'($past(frame_num) + 1'b1));

    assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(sof_pulse && ufrm_index == '0)) |-> $stable(frame_num));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sof_pulse);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !en) |=> ($stable(ufrm_index) && $stable(frame_num)));

endmodule

bind usb_ufrm_timer usb_ufrm_timer_checker #(
    .BASE_COUNT(BASE_COUNT),
    .ADJ_W     (ADJ_W),
    .ADJ_RESET (ADJ_RESET),
    .IDX_W     (IDX_W),
    .FRAME_W   (FRAME_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sof_pulse (sof_pulse),
    .ufrm_index(ufrm_index),
    .frame_num (frame_num),
    .adj_active(adj_active)
);

// File: tb/usb_ufrm_timer_test.sv
// Bench for the microframe interval timer; uses a short base count so that
// a full frame-number wrap fits in the run.
module usb_ufrm_timer_test;

    localparam int BASE  = 4;
    localparam int NOM   = 32;
    localparam int TBL_N = 6;
    // Each row: adjustment to load, expected period once it is applied.
    localparam int VEC [TBL_N][2] = '{
        '{0,  BASE + 0},
        '{63, BASE + 63},
        '{1,  BASE + 1},
        '{17, BASE + 17},
        '{40, BASE + 40},
        '{32, BASE + 32}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        adj_load = 1'b0;
    logic [5:0]  adj_value = '0;
    logic        sof_pulse;
    logic [2:0]  ufrm_index;
    logic [10:0] frame_num;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    usb_ufrm_timer #(.BASE_COUNT(BASE)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .adj_load  (adj_load),
        .adj_value (adj_value),
        .sof_pulse (sof_pulse),
        .ufrm_index(ufrm_index),
        .frame_num (frame_num)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Counts falling edges until the next strobe and checks that the strobe lasts one cycle.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            adj_load = 1'b0;
            if (n == 1) check(!sof_pulse, "R3 strobe width", int'(sof_pulse), 0);
        end while (!sof_pulse && n < 2000);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        int n;
        int prev_adj;
        int u0;
        int f0;
        int bad;
        int pu;
        int pf;
        bit wrapped;

        repeat (3) @(negedge clk);
        check(!sof_pulse && ufrm_index == 0 && frame_num == 0, "R1 reset outputs",
              int'(ufrm_index) + int'(frame_num) + int'(sof_pulse), 0);

        rst_n = 1'b1;
        en    = 1'b1;
        measure(n);
        check(n == BASE + NOM, "R8 first period", n, BASE + NOM);
        check(ufrm_index == 1 && frame_num == 0, "R5 index on strobe", int'(ufrm_index), 1);

        prev_adj = NOM;
        for (int i = 0; i < TBL_N; i++) begin
            adj_value = 6'(VEC[i][0]);
            adj_load  = 1'b1;
            measure(n);
            check(n == BASE + prev_adj, "R4 period in progress unchanged", n, BASE + prev_adj);
            measure(n);
            check(n == VEC[i][1], "R2 R9 period after load", n, VEC[i][1]);
            prev_adj = VEC[i][0];
        end

        en  = 1'b0;
        u0  = int'(ufrm_index);
        f0  = int'(frame_num);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (sof_pulse || int'(ufrm_index) != u0 || int'(frame_num) != f0) bad++;
        end
        check(bad == 0, "R7 hold while disabled", bad, 0);
        en = 1'b1;
        measure(n);
        check(n == BASE + prev_adj, "R7 resume period", n, BASE + prev_adj);

        adj_value = 6'd0;
        adj_load  = 1'b1;
        measure(n);
        bad     = 0;
        wrapped = 1'b0;
        for (int k = 0; k < 20000 && !wrapped; k++) begin
            pu = int'(ufrm_index);
            pf = int'(frame_num);
            measure(n);
            if (int'(ufrm_index) != ((pu + 1) % 8)) bad++;
            if (pu == 7 && int'(frame_num) != ((pf + 1) % 2048)) bad++;
            if (pu != 7 && int'(frame_num) != pf) bad++;
            if (n != BASE) bad++;
            if (pf == 2047 && pu == 7) begin
                wrapped = 1'b1;
                check(frame_num == 0 && ufrm_index == 0, "R6 frame wrap to zero",
                      int'(frame_num), 0);
            end
        end
        check(wrapped, "R6 frame wrap reached", int'(wrapped), 1);
        check(bad == 0, "R5 R6 R9 sequence across frames", bad, 0);

        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!sof_pulse && ufrm_index == 0 && frame_num == 0, "R1 reset mid-run",
              int'(ufrm_index) + int'(frame_num), 0);
        rst_n = 1'b1;
        measure(n);
        check(n == BASE + NOM, "R1 adjustment restored to nominal", n, BASE + NOM);

        summary();
        $finish;
    end

endmodule